// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array that software manages. Software fills and inspects the array through a maintenance port. That port offers four operations: a write to a chosen slot, a read of a chosen slot, a write to a slot the hardware picks, and a probe that searches every slot for a page number. A separate translation port takes a 32-bit virtual address and an access direction. It returns the physical address, or one of three fault flags: no matching tag, a tag that matched an entry not marked valid, and a store to a page without write permission.

Each slot holds two 32-bit words. The tag word carries the virtual page number in bits 31:12. Its bits 11:0 are stored as zero, which includes the unused address-space-ID field in bits 11:6. The data word carries the physical page number in bits 31:12, the uncached flag in bit 11, the write-permission flag in bit 10, the valid flag in bit 9 and the global flag in bit 8. Its bits 7:0 are stored as zero. Hardware never sets the write-permission flag. A tag comparison ignores the valid flag. To empty the array, software fills every slot with a distinct page number at or above 0x80000, because such tags never hit on translation.

Both ports answer one clock after the request, with registered outputs. The maintenance opcodes are 0 (write to the slot named by the index), 1 (read from that slot), 2 (write to the hardware-chosen slot) and 3 (probe).

Top module: `xlat_cam_tlb`

## Requirements
- R1: Synchronous reset loads slot i with tag word (0x80000+i)<<12 and data word 0. It clears both response valids and sets the replacement counter to NUM_ENTRIES-1.
- R2: Opcode 0 stores the tag word ANDed with 0xFFFFF000 and the data word ANDed with 0xFFFFFF00 at the given index. Opcode 1 returns both stored words of that index. Every maintenance response appears exactly one cycle after its request, and its index output carries the slot used.
- R3: Opcode 2 writes to the slot held by the replacement counter and reports that slot. The counter steps down by one every clock, from NUM_ENTRIES-1 to RAND_FLOOR, then wraps to NUM_ENTRIES-1, so slots below RAND_FLOOR are never chosen.
- R4: Opcode 3 compares tag bits 31:12 against every slot, whatever the valid flag. A hit returns the slot index. A miss returns 0x80000000. The data-word input has no effect.
- R5: When several slots match, both the probe and the translation report the lowest matching index and raise their multiple-match flag.
- R6: Virtual addresses 0x80000000 through 0xBFFFFFFF bypass the array. The physical address is the virtual address ANDed with 0x1FFFFFFF, and no fault is raised.
- R7: Any other address whose page number matches no slot raises the miss flag. Slots whose tag has bit 31 set never match on translation.
- R8: A translation that matches a slot whose valid flag is clear raises the invalid flag.
- R9: A store that matches a valid slot whose write-permission flag is clear raises the modify flag. A load from the same slot completes.
- R10: A translation with no fault returns {physical page, offset} and the slot's uncached flag, one cycle after the request. While any fault flag is set, the physical address and the uncached flag are zero.
- R11: At most one fault flag is set per response. Miss has priority over invalid, and invalid over modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mnt_valid | input | 1 | Maintenance request strobe |
| mnt_op | input | 2 | Opcode: 0 indexed write, 1 indexed read, 2 hardware-slot write, 3 probe |
| mnt_index | input | IDX_W (6) | Slot for opcodes 0 and 1 |
| mnt_hi | input | 32 | Tag word, or probe key in bits 31:12 |
| mnt_lo | input | 32 | Data word |
| mnt_rsp_valid | output | 1 | Maintenance response strobe |
| mnt_rsp_hi | output | 32 | Tag word read by opcode 1, else zero |
| mnt_rsp_lo | output | 32 | Data word read by opcode 1, else zero |
| mnt_rsp_index | output | 32 | Slot used, probe hit index, or 0x80000000 on a probe miss |
| mnt_rsp_multi | output | 1 | Probe matched more than one slot |
| xl_valid | input | 1 | Translation request strobe |
| xl_vaddr | input | 32 | Virtual address |
| xl_is_write | input | 1 | 1 for a store, 0 for a load |
| xl_rsp_valid | output | 1 | Translation response strobe |
| xl_paddr | output | 32 | Physical address |
| xl_nocache | output | 1 | Uncached flag of the matched slot |
| xl_miss | output | 1 | No tag match |
| xl_invalid | output | 1 | Match on a slot not marked valid |
| xl_modify | output | 1 | Store to a page without write permission |
| xl_multi | output | 1 | Translation matched more than one slot |

## Verification
The bench uses the default parameters: 64 slots and a replacement floor of 8. With these values the counter sweeps its 56 legal slots in 56 clocks, so the bench can wait for the counter to reach 8 and then issue two back-to-back hardware-slot writes that straddle the wrap to 63. It also predicts each chosen slot from its own count of clocks since reset. At 64 slots, the slot pairs built for multiple matches and the reset pattern at indices 32 and 63 can be checked directly by probes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_WR_IDX  = 2'd0,
    OP_RD_IDX  = 2'd1,
    OP_WR_RAND = 2'd2,
    OP_PROBE   = 2'd3
  } tlb_op_e;

  localparam int          VPN_LSB     = 12;
  localparam int          VPN_W       = 32 - VPN_LSB;
  localparam int          BIT_NOCACHE = 11;
  localparam int          BIT_WRITE   = 10;
  localparam int          BIT_VALID   = 9;
  localparam logic [31:0] TAG_KEEP    = 32'hFFFF_F000;
  localparam logic [31:0] DATA_KEEP   = 32'hFFFF_FF00;
  localparam logic [31:0] PROBE_NONE  = 32'h8000_0000;
  localparam logic [31:0] DIRECT_MASK = 32'h1FFF_FFFF;
  localparam logic [VPN_W-1:0] KSEG_BASE = 20'h80000;
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
  parameter  int NUM_ENTRIES = 64,
  parameter  int RAND_FLOOR  = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] slot
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(RAND_FLOOR);

  always_ff @(posedge clk) begin
    if (rst || slot == BOT) slot <= TOP;
    else                    slot <= slot - 1'b1;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter  int N     = 64,
  parameter  int TAG_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            elig,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic                    multi,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign m[i] = elig[i] && (tags[i] == key);
  end

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
  end

  assign hit   = |m;
  assign multi = (m & (m - 1'b1)) != '0;
endmodule

// File: rtl/xlat_cam_tlb.sv
module xlat_cam_tlb
  import tlb_pkg::*;
#(
  parameter  int NUM_ENTRIES = 64,
  parameter  int RAND_FLOOR  = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mnt_valid,
  input  logic [1:0]       mnt_op,
  input  logic [IDX_W-1:0] mnt_index,
  input  logic [31:0]      mnt_hi,
  input  logic [31:0]      mnt_lo,
  output logic             mnt_rsp_valid,
  output logic [31:0]      mnt_rsp_hi,
  output logic [31:0]      mnt_rsp_lo,
  output logic [31:0]      mnt_rsp_index,
  output logic             mnt_rsp_multi,
  input  logic             xl_valid,
  input  logic [31:0]      xl_vaddr,
  input  logic             xl_is_write,
  output logic             xl_rsp_valid,
  output logic [31:0]      xl_paddr,
  output logic             xl_nocache,
  output logic             xl_miss,
  output logic             xl_invalid,
  output logic             xl_modify,
  output logic             xl_multi
);
  logic [NUM_ENTRIES-1:0][31:0]      tag_q, data_q;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] vpn;
  logic [NUM_ENTRIES-1:0]            all_ok, xl_ok;
  logic [IDX_W-1:0]                  rnd_slot, wr_slot, pr_idx, xl_idx;
  logic                              pr_hit, pr_multi, xl_hit, xl_mh;
  tlb_op_e                           op;

  assign op = tlb_op_e'(mnt_op);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_tag
    assign vpn[i]    = tag_q[i][31:VPN_LSB];
    assign all_ok[i] = 1'b1;
    assign xl_ok[i]  = !tag_q[i][31];  // kernel-region tags never translate
  end

  tlb_rand_ctr #(.NUM_ENTRIES(NUM_ENTRIES), .RAND_FLOOR(RAND_FLOOR)) u_rnd (
    .clk(clk), .rst(rst), .slot(rnd_slot)
  );

  tlb_match #(.N(NUM_ENTRIES), .TAG_W(VPN_W)) u_probe (
    .tags(vpn), .elig(all_ok), .key(mnt_hi[31:VPN_LSB]),
    .hit(pr_hit), .multi(pr_multi), .idx(pr_idx)
  );

  tlb_match #(.N(NUM_ENTRIES), .TAG_W(VPN_W)) u_xlat (
    .tags(vpn), .elig(xl_ok), .key(xl_vaddr[31:VPN_LSB]),
    .hit(xl_hit), .multi(xl_mh), .idx(xl_idx)
  );

  // entry storage
  assign wr_slot = (op == OP_WR_RAND) ? rnd_slot : mnt_index;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tag_q[i]  <= {VPN_W'(KSEG_BASE + VPN_W'(i)), 12'h000};
        data_q[i] <= '0;
      end
    end else if (mnt_valid && (op == OP_WR_IDX || op == OP_WR_RAND)) begin
      tag_q[wr_slot]  <= mnt_hi & TAG_KEEP;
      data_q[wr_slot] <= mnt_lo & DATA_KEEP;
    end
  end

  // maintenance response
  always_ff @(posedge clk) begin
    if (rst) begin
      mnt_rsp_valid <= 1'b0;
      mnt_rsp_hi    <= '0;
      mnt_rsp_lo    <= '0;
      mnt_rsp_index <= '0;
      mnt_rsp_multi <= 1'b0;
    end else begin
      mnt_rsp_valid <= mnt_valid;
      if (mnt_valid) begin
        mnt_rsp_hi    <= (op == OP_RD_IDX) ? tag_q[mnt_index]  : '0;
        mnt_rsp_lo    <= (op == OP_RD_IDX) ? data_q[mnt_index] : '0;
        mnt_rsp_multi <= (op == OP_PROBE) && pr_multi;
        unique case (op)
          OP_WR_RAND: mnt_rsp_index <= 32'(rnd_slot);
          OP_PROBE:   mnt_rsp_index <= pr_hit ? 32'(pr_idx) : PROBE_NONE;
          default:    mnt_rsp_index <= 32'(mnt_index);
        endcase
      end
    end
  end

  // translation
  logic [31:0] sel_data, pa_d;
  logic        bypass, f_miss, f_inv, f_mod, fault;

  assign sel_data = data_q[xl_idx];
  assign bypass   = xl_vaddr[31:30] == 2'b10;
  assign f_miss   = !bypass && !xl_hit;
  assign f_inv    = !bypass && xl_hit && !sel_data[BIT_VALID];
  assign f_mod    = !bypass && xl_hit && sel_data[BIT_VALID] &&
                    xl_is_write && !sel_data[BIT_WRITE];
  assign fault    = f_miss || f_inv || f_mod;

  always_comb begin
    if (bypass)     pa_d = xl_vaddr & DIRECT_MASK;
    else if (fault) pa_d = '0;
    else            pa_d = {sel_data[31:VPN_LSB], xl_vaddr[VPN_LSB-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_rsp_valid <= 1'b0;
      xl_paddr     <= '0;
      xl_nocache   <= 1'b0;
      xl_miss      <= 1'b0;
      xl_invalid   <= 1'b0;
      xl_modify    <= 1'b0;
      xl_multi     <= 1'b0;
    end else begin
      xl_rsp_valid <= xl_valid;
      if (xl_valid) begin
        xl_paddr   <= pa_d;
        xl_nocache <= !bypass && !fault && sel_data[BIT_NOCACHE];
        xl_miss    <= f_miss;
        xl_invalid <= f_inv;
        xl_modify  <= f_mod;
        xl_multi   <= !bypass && xl_mh;
      end
    end
  end
endmodule

// File: rtl/xlat_cam_tlb_chk.sv
module xlat_cam_tlb_chk #(
  parameter  int NUM_ENTRIES = 64,
  parameter  int RAND_FLOOR  = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             mnt_valid,
  input logic [1:0]       mnt_op,
  input logic [IDX_W-1:0] mnt_index,
  input logic [31:0]      mnt_rsp_index,
  input logic             mnt_rsp_valid,
  input logic             mnt_rsp_multi,
  input logic             xl_valid,
  input logic [31:0]      xl_vaddr,
  input logic             xl_is_write,
  input logic             xl_rsp_valid,
  input logic [31:0]      xl_paddr,
  input logic             xl_nocache,
  input logic             xl_miss,
  input logic             xl_invalid,
  input logic             xl_modify
);
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (rst)
    mnt_rsp_valid == $past(mnt_valid && !rst));

  a_r10_xl_latency: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid == $past(xl_valid && !rst));

  a_r3_rand_range: assert property (@(posedge clk) disable iff (rst)
    (mnt_rsp_valid && $past(mnt_op) == 2'd2) |->
      (mnt_rsp_index >= 32'(RAND_FLOOR) && mnt_rsp_index <= 32'(NUM_ENTRIES - 1)));

  a_r4_probe_none: assert property (@(posedge clk) disable iff (rst)
    (mnt_rsp_valid && $past(mnt_op) == 2'd3 && mnt_rsp_index[31]) |->
      (mnt_rsp_index == 32'h8000_0000 && !mnt_rsp_multi));

  a_r5_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
    mnt_rsp_multi |-> !mnt_rsp_index[31]);

  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && $past(xl_vaddr[31:30]) == 2'b10) |->
      (xl_paddr == ($past(xl_vaddr) & 32'h1FFF_FFFF) && !xl_miss && !xl_invalid && !xl_modify));

  a_r9_modify_store: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && xl_modify) |-> $past(xl_is_write));

  a_r11_one_fault: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid |-> $onehot0({xl_miss, xl_invalid, xl_modify}));

  a_r10_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && (xl_miss || xl_invalid || xl_modify)) |->
      (xl_paddr == 32'h0 && !xl_nocache));
endmodule

bind xlat_cam_tlb xlat_cam_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES), .RAND_FLOOR(RAND_FLOOR)) u_chk (.*);

// File: tb/test_xlat_cam_tlb.sv
`timescale 1ns/1ps
module test_xlat_cam_tlb;
  localparam int N = 64;
  localparam int FLOOR = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mnt_valid = 1'b0;
  logic [1:0]    mnt_op = '0;
  logic [IW-1:0] mnt_index = '0;
  logic [31:0]   mnt_hi = '0, mnt_lo = '0;
  logic          mnt_rsp_valid, mnt_rsp_multi;
  logic [31:0]   mnt_rsp_hi, mnt_rsp_lo, mnt_rsp_index;
  logic          xl_valid = 1'b0, xl_is_write = 1'b0;
  logic [31:0]   xl_vaddr = '0;
  logic          xl_rsp_valid, xl_nocache, xl_miss, xl_invalid, xl_modify, xl_multi;
  logic [31:0]   xl_paddr;

  int checks = 0, fails = 0;
  int ecnt = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

  xlat_cam_tlb #(.NUM_ENTRIES(N), .RAND_FLOOR(FLOOR)) i_xlat_cam_tlb (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the response visible
  task automatic mnt_do(input logic [1:0] op, input int idx, input logic [31:0] hi, input logic [31:0] lo);
    mnt_valid = 1'b1; mnt_op = op; mnt_index = IW'(idx); mnt_hi = hi; mnt_lo = lo;
    @(negedge clk);
    mnt_valid = 1'b0;
  endtask

  task automatic xl_do(input logic w, input logic [31:0] va);
    xl_valid = 1'b1; xl_is_write = w; xl_vaddr = va;
    @(negedge clk);
    xl_valid = 1'b0;
  endtask

  // {write, vaddr, paddr, nocache, miss, invalid, modify, multi}
  localparam int NV = 14;
  localparam logic [69:0] XV [NV] = '{
    {1'b0, 32'h0040_0ABC, 32'h1234_5ABC, 5'b00000},  // R10 load ok
    {1'b1, 32'h0040_0ABC, 32'h1234_5ABC, 5'b00000},  // R10 store ok
    {1'b0, 32'h0040_1010, 32'h2222_2010, 5'b00000},  // R9 load on read-only
    {1'b1, 32'h0040_1010, 32'h0000_0000, 5'b00010},  // R9 store -> modify
    {1'b0, 32'h0040_2000, 32'h0000_0000, 5'b00100},  // R8 invalid
    {1'b1, 32'h0040_2000, 32'h0000_0000, 5'b00100},  // R11 invalid beats modify
    {1'b0, 32'h0070_0000, 32'h0000_0000, 5'b01000},  // R7 miss
    {1'b0, 32'h8000_1234, 32'h0000_1234, 5'b00000},  // R6 bypass
    {1'b1, 32'hA034_5678, 32'h0034_5678, 5'b00000},  // R6 bypass store
    {1'b0, 32'hBFFF_FFFC, 32'h1FFF_FFFC, 5'b00000},  // R6 top of window
    {1'b0, 32'hC000_0010, 32'h0000_0000, 5'b01000},  // R7 kernel tag excluded
    {1'b0, 32'h0060_0044, 32'h5555_5044, 5'b00001},  // R5 lowest of two
    {1'b0, 32'h0050_0004, 32'h4444_4004, 5'b10000},  // R10 uncached
    {1'b1, 32'h7FFF_F000, 32'h0000_0000, 5'b01000}   // R7 miss high user
  };

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mnt_rsp_valid in reset", 32'(mnt_rsp_valid), 32'h0);
    chk("R1 xl_rsp_valid in reset", 32'(xl_rsp_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset contents
    mnt_do(2'd1, 7, '0, '0);
    chk("R1 tag after reset", mnt_rsp_hi, 32'h8000_7000);
    chk("R1 data after reset", mnt_rsp_lo, 32'h0);
    mnt_do(2'd3, 0, 32'h8002_0000, '0);
    chk("R1/R4 probe reset slot 32", mnt_rsp_index, 32'd32);
    mnt_do(2'd3, 0, 32'h8003_F000, '0);
    chk("R1/R4 probe reset slot 63", mnt_rsp_index, 32'd63);

    // R2 setup with masking
    mnt_do(2'd0, 0, 32'h0040_0FFF, 32'h1234_56FF);
    chk("R2 write index", mnt_rsp_index, 32'd0);
    mnt_do(2'd0, 1, 32'h0040_1000, 32'h2222_2200);
    mnt_do(2'd0, 2, 32'h0040_2000, 32'h3333_3400);
    mnt_do(2'd0, 3, 32'h0050_0000, 32'h4444_4E00);
    mnt_do(2'd0, 4, 32'hC000_0000, 32'h7777_7600);
    mnt_do(2'd0, 9, 32'h0060_0000, 32'h6666_6600);
    mnt_do(2'd0, 5, 32'h0060_0000, 32'h5555_5600);
    mnt_do(2'd1, 0, '0, '0);
    chk("R2 tag masked", mnt_rsp_hi, 32'h0040_0000);
    chk("R2 data masked", mnt_rsp_lo, 32'h1234_5600);
    chk("R2 read index", mnt_rsp_index, 32'd0);
    chk("R2 rsp valid", 32'(mnt_rsp_valid), 32'h1);

    // translation table
    for (int k = 0; k < NV; k++) begin
      logic [69:0] v;
      v = XV[k];
      xl_do(v[69], v[68:37]);
      chk($sformatf("R10 paddr vec %0d", k), xl_paddr, v[36:5]);
      chk($sformatf("R7/R8/R9/R11 flags vec %0d", k),
          {27'h0, xl_nocache, xl_miss, xl_invalid, xl_modify, xl_multi}, {27'h0, v[4:0]});
    end

    // R4 probes
    mnt_do(2'd3, 0, 32'h0040_2000, '0);
    chk("R4 probe hits invalid slot", mnt_rsp_index, 32'd2);
    mnt_do(2'd3, 0, 32'h0040_2ABC, 32'hFFFF_FFFF);
    chk("R4 probe ignores data word", mnt_rsp_index, 32'd2);
    chk("R4 probe single no multi", 32'(mnt_rsp_multi), 32'h0);
    mnt_do(2'd3, 0, 32'h0070_0000, '0);
    chk("R4 probe miss code", mnt_rsp_index, 32'h8000_0000);
    mnt_do(2'd3, 0, 32'hC000_0000, '0);
    chk("R4 probe finds kernel tag", mnt_rsp_index, 32'd4);
    mnt_do(2'd3, 0, 32'h0060_0000, '0);
    chk("R5 probe lowest", mnt_rsp_index, 32'd5);
    chk("R5 probe multi flag", 32'(mnt_rsp_multi), 32'h1);

    // R3 replacement counter wrap
    while ((ecnt % (N - FLOOR)) != (N - FLOOR - 1)) @(negedge clk);
    begin
      int e1;
      e1 = (N - 1) - (ecnt % (N - FLOOR));
      mnt_do(2'd2, 0, 32'h0080_1000, 32'h0ABC_D600);
      chk("R3 random slot at floor", mnt_rsp_index, 32'(e1));
      chk("R3 floor value", mnt_rsp_index, 32'(FLOOR));
      mnt_do(2'd2, 0, 32'h0080_2000, 32'h0BCD_E600);
      chk("R3 random slot after wrap", mnt_rsp_index, 32'(N - 1));
    end
    mnt_do(2'd3, 0, 32'h0080_1000, '0);
    chk("R3 probe random write 1", mnt_rsp_index, 32'(FLOOR));
    mnt_do(2'd3, 0, 32'h0080_2000, '0);
    chk("R3 probe random write 2", mnt_rsp_index, 32'(N - 1));
    xl_do(1'b1, 32'h0080_2123);
    chk("R3 translate random entry", xl_paddr, 32'h0BCD_E123);
    repeat (7) @(negedge clk);
    begin
      int e2;
      e2 = (N - 1) - (ecnt % (N - FLOOR));
      mnt_do(2'd2, 0, 32'h0080_3000, 32'h0);
      chk("R3 random slot mid sweep", mnt_rsp_index, 32'(e2));
    end

    // R1 second reset
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mnt_do(2'd2, 0, 32'h0090_0000, '0);
    chk("R1 counter starts at top", mnt_rsp_index, 32'(N - 1));
    mnt_do(2'd1, 9, '0, '0);
    chk("R1 slot 9 restored", mnt_rsp_hi, 32'h8000_9000);
    xl_do(1'b0, 32'h0060_0000);
    chk("R1/R7 old mapping gone", 32'(xl_miss), 32'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule